// File: doc/BRIEF.md
# Divided Reference Phase Detector

This block compares a local station oscillator against an external frequency reference and tells a charge pump which way to steer. The local clock and the chosen reference each pass a two-stage synchronizer and a rising-edge detector. Each then feeds a counter that turns the edge stream into one comparison event per compare period. The local divider is fixed. The reference divider is picked by a two-bit frequency select, so a 5, 10 or 20 MHz reference and a 16.8 MHz local clock both reach the same 200 kHz compare rate.

A phase-frequency detector keeps one flag per side. The side whose divided edge comes first raises its flag, and that flag drives a steering pulse until the other side's edge arrives. A pump-up pulse means the local edge was late and the oscillator must speed up. A pump-down pulse means the local edge was early and the oscillator must slow down. When both flags are set they clear together on the next cycle, so each pulse lasts exactly as many cycles as the edge difference.

Each finished comparison reports its pulse width to a lock monitor. The monitor declares lock after a programmable run of consecutive comparisons whose width stays below a programmable window. All logic runs on one fast sampling clock, and the two oscillators enter as plain level inputs.

Top module: `ref_phase_detector`

## Requirements
- R1: With default parameters the local divider emits one divided edge per 84 local rising edges. The reference divider emits one per 25, 50 or 100 reference rising edges when `ref_sel` is 0 (5 MHz), 1 (10 MHz) or 2 (20 MHz). All three counts are parameters.
- R2: When the divided reference edge comes d cycles before the divided local edge, `pump_up` is high for exactly d consecutive cycles and `pump_down` stays low.
- R3: When the divided local edge comes d cycles before the divided reference edge, `pump_down` is high for exactly d consecutive cycles and `pump_up` stays low.
- R4: `pump_up` and `pump_down` are never high in the same cycle. When both divided edges fall in the same cycle, neither output pulses.
- R5: `ref_sel` = 3 holds both dividers at zero. While it stays there, no steering pulse is produced and `locked` stays low.
- R6: When `ref_sel` changes, both dividers, both detector flags and the lock state are cleared at the next clock edge. Comparison then restarts from zero counts with the new reference ratio.
- R7: `locked` rises one cycle after the comparison that completes `lock_cycles` consecutive comparisons, each with a pulse width below `lock_window`.
- R8: A comparison whose pulse width is equal to or greater than `lock_window` drops `locked` and restarts the consecutive count.
- R9: While `rst` is high, `pump_up`, `pump_down` and `locked` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than both oscillators |
| rst | input | 1 | Synchronous active-high reset |
| loc_clk_in | input | 1 | Level of the local station oscillator |
| ref_clk_in | input | 1 | Level of the selected external reference |
| ref_sel | input | 2 | Reference frequency select: 0 = 5 MHz, 1 = 10 MHz, 2 = 20 MHz, 3 = off |
| lock_cycles | input | LOCK_W | Consecutive good comparisons required for lock |
| lock_window | input | WIDTH_W | Pulse width, in clk cycles, at or above which a comparison is bad |
| pump_up | output | 1 | Steer the oscillator faster (local edge late) |
| pump_down | output | 1 | Steer the oscillator slower (local edge early) |
| locked | output | 1 | Lock indicator |

## Verification
The bench builds the block with a local divide of 6 and reference divides of 2, 4 and 8. The local clock has an 8-cycle period and the reference clock has a period of 24, 12 or 6 cycles. Every select value therefore reaches a 48-cycle compare period, and dozens of comparisons fit in a short run. Clock phase offsets are chosen at random or set directly, which produces early, late and coincident edges. The expected pulse width follows in closed form from the offsets and the divide ratios. A narrow `LOCK_W` of 4 keeps the lock count and the window boundaries within a few comparisons.

// File: rtl/pdet_pkg.sv
package pdet_pkg;

    // Reference frequency select encoding
    typedef enum logic [1:0] {
        FSEL_5M  = 2'd0,
        FSEL_10M = 2'd1,
        FSEL_20M = 2'd2,
        FSEL_OFF = 2'd3
    } fsel_e;

    // Detector state: one flag per side, set by that side's divided edge
    typedef struct packed {
        logic ref_seen;
        logic loc_seen;
    } pd_flags_t;

    // Reference divide count for a given select value
    function automatic int unsigned pick_ref_div(input fsel_e sel,
                                                 input int unsigned div_5m,
                                                 input int unsigned div_10m,
                                                 input int unsigned div_20m);
        case (sel)
            FSEL_5M:  return div_5m;
            FSEL_10M: return div_10m;
            default:  return div_20m;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pdet_edge_sync.sv
module pdet_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [2:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[1:0], raw_in};
        end
    end

    // pipe[1] is the second synchronizer stage and pipe[2] its delayed copy
    assign rise = pipe[1] & ~pipe[2];

endmodule

// File: rtl/pdet_divider.sv
module pdet_divider #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hold,
    input  logic             tick,
    input  logic [CNT_W-1:0] div_val,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = div_val - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr || hold) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt == last) begin
                    cnt   <= '0;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
        hold |=> !pulse); // R5

    AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick)); // R1

endmodule

// File: rtl/pdet_pfd_core.sv
module pdet_pfd_core
    import pdet_pkg::*;
#(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               ref_ev,
    input  logic               loc_ev,
    output logic               up,
    output logic               down,
    output logic               cmp_done,
    output logic [WIDTH_W-1:0] cmp_width
);
    localparam logic [WIDTH_W-1:0] WIDTH_MAX = '1;

    pd_flags_t          flg;
    pd_flags_t          flg_n;
    logic               both;
    logic [WIDTH_W-1:0] width_q;

    always_comb begin
        both           = flg.ref_seen & flg.loc_seen;
        flg_n.ref_seen = (flg.ref_seen & ~both) | ref_ev;
        flg_n.loc_seen = (flg.loc_seen & ~both) | loc_ev;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flg     <= '0;
            width_q <= '0;
        end else begin
            flg <= flg_n;
            if (both) begin
                width_q <= '0;
            end else if ((flg.ref_seen ^ flg.loc_seen) && (width_q != WIDTH_MAX)) begin
                width_q <= width_q + 1'b1;
            end
        end
    end

    // Reference first: local is late, speed the oscillator up
    assign up        = flg.ref_seen & ~flg.loc_seen;
    // Local first: local is early, slow the oscillator down
    assign down      = flg.loc_seen & ~flg.ref_seen;
    assign cmp_done  = both;
    assign cmp_width = width_q;

    AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (both && !ref_ev && !loc_ev && !clr) |=> (!up && !down && !cmp_done)); // R4

    AST_UP_UNTIL_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (up && !loc_ev && !clr) |=> up); // R2

    AST_DOWN_UNTIL_REF: assert property (@(posedge clk) disable iff (rst)
        (down && !ref_ev && !clr) |=> down); // R3

endmodule

// File: rtl/pdet_lock_mon.sv
module pdet_lock_mon #(
    parameter int unsigned WIDTH_W = 8,
    parameter int unsigned LOCK_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               cmp_done,
    input  logic [WIDTH_W-1:0] cmp_width,
    input  logic [WIDTH_W-1:0] window,
    input  logic [LOCK_W-1:0]  need,
    output logic               locked
);
    localparam logic [LOCK_W-1:0] GOOD_MAX = '1;

    logic [LOCK_W-1:0] good_cnt;
    logic [LOCK_W-1:0] good_nxt;
    logic              good_cmp;

    assign good_cmp = cmp_width < window;
    assign good_nxt = (good_cnt == GOOD_MAX) ? good_cnt : good_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            good_cnt <= '0;
            locked   <= 1'b0;
        end else if (cmp_done) begin
            if (good_cmp) begin
                good_cnt <= good_nxt;
                locked   <= (good_nxt >= need);
            end else begin
                good_cnt <= '0;
                locked   <= 1'b0;
            end
        end
    end

    AST_LOCK_ON_GOOD: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cmp_done && (cmp_width < window))); // R7

    AST_BAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && (cmp_width >= window)) |=> !locked); // R8

endmodule

// File: rtl/ref_phase_detector.sv
module ref_phase_detector
    import pdet_pkg::*;
#(
    parameter int unsigned LOC_DIV     = 84,
    parameter int unsigned REF_DIV_5M  = 25,
    parameter int unsigned REF_DIV_10M = 50,
    parameter int unsigned REF_DIV_20M = 100,
    parameter int unsigned WIDTH_W     = 8,
    parameter int unsigned LOCK_W      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               loc_clk_in,
    input  logic               ref_clk_in,
    input  logic [1:0]         ref_sel,
    input  logic [LOCK_W-1:0]  lock_cycles,
    input  logic [WIDTH_W-1:0] lock_window,
    output logic               pump_up,
    output logic               pump_down,
    output logic               locked
);
    localparam int unsigned MAX_DIV = max3(LOC_DIV, REF_DIV_5M, max3(REF_DIV_10M, REF_DIV_20M, 1));
    localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);
    localparam int unsigned N_SRC   = 2;   // index 0: local, index 1: reference

    fsel_e              sel_now;
    fsel_e              sel_q;
    logic               sel_chg;
    logic               div_hold;
    logic [N_SRC-1:0]   raw_lvl;
    logic [N_SRC-1:0]   src_rise;
    logic [N_SRC-1:0]   div_ev;
    logic [CNT_W-1:0]   div_val [N_SRC];
    logic               cmp_done;
    logic [WIDTH_W-1:0] cmp_width;

    assign sel_now  = fsel_e'(ref_sel);
    assign sel_chg  = (sel_now != sel_q);
    assign div_hold = (sel_now == FSEL_OFF);
    assign raw_lvl  = {ref_clk_in, loc_clk_in};

    assign div_val[0] = CNT_W'(LOC_DIV);
    assign div_val[1] = CNT_W'(pick_ref_div(sel_now, REF_DIV_5M, REF_DIV_10M, REF_DIV_20M));

    always_ff @(posedge clk) begin
        sel_q <= sel_now;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        pdet_edge_sync u_sync (
            .clk    (clk),
            .rst    (rst),
            .raw_in (raw_lvl[g]),
            .rise   (src_rise[g])
        );

        pdet_divider #(.CNT_W(CNT_W)) u_div (
            .clk     (clk),
            .rst     (rst),
            .clr     (sel_chg),
            .hold    (div_hold),
            .tick    (src_rise[g]),
            .div_val (div_val[g]),
            .pulse   (div_ev[g])
        );
    end

    pdet_pfd_core #(.WIDTH_W(WIDTH_W)) u_pfd (
        .clk       (clk),
        .rst       (rst),
        .clr       (sel_chg),
        .ref_ev    (div_ev[1]),
        .loc_ev    (div_ev[0]),
        .up        (pump_up),
        .down      (pump_down),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width)
    );

    pdet_lock_mon #(.WIDTH_W(WIDTH_W), .LOCK_W(LOCK_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .clr       (sel_chg),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width),
        .window    (lock_window),
        .need      (lock_cycles),
        .locked    (locked)
    );

    AST_SEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sel_chg |=> (!pump_up && !pump_down && !locked)); // R6

    AST_OFF_NO_STEER: assert property (@(posedge clk) disable iff (rst)
        (div_hold && $past(div_hold)) |-> (!pump_up && !pump_down)); // R5

endmodule

// File: tb/test_ref_phase_detector.sv
`timescale 1ns/1ps
module test_ref_phase_detector;
    localparam int LOC_DIV = 6;
    localparam int RD0 = 2, RD1 = 4, RD2 = 8;
    localparam int WW = 8, LW = 4;
    localparam int PL = 8;              // local period, cycles
    localparam int SETTLE = 310;        // at least five comparisons

    logic clk = 1'b0, rst = 1'b1, loc_in = 1'b0, ref_in = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [LW-1:0] lock_cycles = 4'd3;
    logic [WW-1:0] lock_window = 8'd4;
    logic up, down, locked;

    ref_phase_detector #(.LOC_DIV(LOC_DIV), .REF_DIV_5M(RD0), .REF_DIV_10M(RD1),
                         .REF_DIV_20M(RD2), .WIDTH_W(WW), .LOCK_W(LW)) i_ref_phase_detector (
        .clk(clk), .rst(rst), .loc_clk_in(loc_in), .ref_clk_in(ref_in), .ref_sel(sel),
        .lock_cycles(lock_cycles), .lock_window(lock_window),
        .pump_up(up), .pump_down(down), .locked(locked));

    always #10 clk = ~clk;

    int checks = 0, fails = 0, wd = 0;

    // Oscillator models: levels derived from a cycle count
    logic gen_on = 1'b0;
    int gen_c = 0, gen_pr = 24, gen_sl = 0, gen_sr = 0;
    always @(negedge clk) begin
        if (!gen_on) begin
            loc_in <= 1'b0; ref_in <= 1'b0; gen_c <= 0;
        end else begin
            loc_in <= (gen_c >= gen_sl) && (((gen_c - gen_sl) % PL) >= PL/2);
            ref_in <= (gen_c >= gen_sr) && (((gen_c - gen_sr) % gen_pr) >= gen_pr/2);
            gen_c  <= gen_c + 1;
        end
    end

    // Pulse monitor
    logic mon_clr = 1'b0;
    int up_len, dn_len, up_last, dn_last, up_runs, dn_runs, overlap;
    always @(negedge clk) begin
        if (mon_clr) begin
            up_len = 0; dn_len = 0; up_last = 0; dn_last = 0;
            up_runs = 0; dn_runs = 0; overlap = 0;
        end else begin
            if (up) up_len++; else if (up_len > 0) begin up_last = up_len; up_runs++; up_len = 0; end
            if (down) dn_len++; else if (dn_len > 0) begin dn_last = dn_len; dn_runs++; dn_len = 0; end
            if (up && down) overlap++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic int period_of(input int s);
        case (s)
            0: return 24;
            1: return 12;
            default: return 6;
        endcase
    endfunction

    // Reference divided edge minus local divided edge, in cycles
    function automatic int exp_d(input int sl, input int sr, input int pr);
        return sr - sl + (PL - pr) / 2;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start(input int s, input int sl, input int sr);
        wait_cyc(1);
        gen_on = 1'b0;
        wait_cyc(4);
        rst = 1'b1; sel = 2'(s);
        wait_cyc(2);
        rst = 1'b0;
        gen_sl = sl; gen_sr = sr; gen_pr = period_of(s);
        mon_clr = 1'b1; gen_on = 1'b1;
        wait_cyc(1);
        mon_clr = 1'b0;
    endtask

    task automatic check_widths(input int d);
        if (d > 0) begin
            check(dn_last == d, "R3 down width (R1 ratios)", dn_last, d);
            check(up_runs == 0, "R3 no up pulse", up_runs, 0);
        end else if (d < 0) begin
            check(up_last == -d, "R2 up width (R1 ratios)", up_last, -d);
            check(dn_runs == 0, "R2 no down pulse", dn_runs, 0);
        end else begin
            check(up_runs + dn_runs == 0, "R4 coincident edges", up_runs + dn_runs, 0);
        end
        check(overlap == 0, "R4 overlap", overlap, 0);
    endtask

    initial begin
        int d;
        void'($urandom(32'd2024));
        // R9: reset state
        wait_cyc(3);
        check(up == 0 && down == 0 && locked == 0, "R9 reset outputs", {up, down, locked}, 0);

        // Random phase patterns over all three reference ratios
        for (int i = 0; i < 16; i++) begin
            int s, sl, sr, w;
            s  = $urandom_range(2, 0);
            sl = $urandom_range(15, 0);
            sr = $urandom_range(15, 0);
            w  = $urandom_range(20, 1);
            lock_cycles = 4'd3; lock_window = 8'(w);
            start(s, sl, sr);
            wait_cyc(SETTLE);
            d = exp_d(sl, sr, period_of(s));
            check_widths(d);
            if (iabs(d) < w) check(locked == 1, "R7 lock in window", locked, 1);
            else             check(locked == 0, "R8 no lock outside window", locked, 0);
        end

        // R4: coincident edges (select 2: sl=1, sr=0 gives d=0)
        lock_window = 8'd4;
        start(2, 1, 0);
        wait_cyc(SETTLE);
        check_widths(0);

        // R5: select 3 keeps everything idle
        start(3, 0, 3);
        wait_cyc(SETTLE);
        check(up_runs + dn_runs == 0, "R5 no steering when off", up_runs + dn_runs, 0);
        check(locked == 0, "R5 no lock when off", locked, 0);

        // R8 / R7 window boundary: width equal to window fails, one below passes
        lock_cycles = 4'd3; lock_window = 8'd5;
        start(2, 0, 4);                       // d = 5
        wait_cyc(SETTLE);
        check(locked == 0, "R8 width equal to window", locked, 0);
        start(2, 0, 3);                       // d = 4
        wait_cyc(SETTLE);
        check(locked == 1, "R7 width below window", locked, 1);

        // R8: narrowing the window drops lock; R7: restoring it relocks
        lock_window = 8'd3;
        wait_cyc(60);
        check(locked == 0, "R8 lock dropped on bad compare", locked, 0);
        lock_window = 8'd5;
        wait_cyc(48 * 4);
        check(locked == 1, "R7 relock after recovery", locked, 1);

        // R7: count of consecutive compares (need 8)
        lock_cycles = 4'd8; lock_window = 8'd4;
        start(2, 1, 0);                       // d = 0, compares near 50 + 48k
        wait_cyc(214 - 1);
        check(locked == 0, "R7 lock before count reached", locked, 0);
        wait_cyc(502 - 214);
        check(locked == 1, "R7 lock after count reached", locked, 1);

        // R6: select change clears state and restarts dividers
        wait_cyc(1);
        gen_on = 1'b0;
        wait_cyc(4);
        check(locked == 1, "R6 precondition locked", locked, 1);
        sel = 2'd0;
        wait_cyc(1);
        check(up == 0 && down == 0 && locked == 0, "R6 cleared on select change",
              {up, down, locked}, 0);
        lock_cycles = 4'd3;
        gen_sl = 10; gen_sr = 0; gen_pr = period_of(0);
        mon_clr = 1'b1; gen_on = 1'b1;
        wait_cyc(1);
        mon_clr = 1'b0;
        wait_cyc(SETTLE);
        d = exp_d(10, 0, period_of(0));       // -18: up pulses
        check(up_last == -d, "R6 restart with new ratio", up_last, -d);
        check(dn_runs == 0, "R6 no down after restart", dn_runs, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule